// File: doc/BRIEF.md
# Phase Controller with Convolutional Key Checker

An eight-phase controller moves through phases PH0 to PH7 while its advance input is high and stays put while it is low. It drives one registered output that is high in the upper half of the ring. Next to this controller, and without sitting on its next-state path, a key generator derives a 3-bit symbol every cycle. The symbol is computed from the present phase, the present output and one bit that is taken from the controller's own next-state logic.

A decoder tracks the stream of symbols as a convolutional code whose trellis states are four colours. It raises a sticky error flag when a symbol cannot follow the colour it expects. The colour of a controller state depends on both the phase and the output bit. As a result, a corrupted output bit is caught in the same way as a corrupted phase bit. Stuck-at forcing inputs on the four register D lines and on the three key lines let a bench inject single faults.

Top module: `cced_top`

## Requirements
- R1: A synchronous active-high reset, sampled at a rising edge, sets phase_o to 0 (PH0), out_o to 0 and err_o to 0. It also loads the decoder's expected colour with the colour of PH0, which is 0.
- R2: With no forcing active, phase_o becomes (phase_o+1) mod 8 at an edge where adv_i is 1, so PH7 goes to PH0. It keeps its value at an edge where adv_i is 0.
- R3: With no forcing active, out_o after each edge equals bit 2 of the new phase_o. It is therefore high exactly in PH4 to PH7 and updates in the same cycle as the phase.
- R4: With no forcing active, err_o stays 0 for any sequence on adv_i.
- R5: The colour of a state with phase p and output o is {p[1], p[0]^p[2]^o}. The key is {colour of the present state, next-phase bit 0}. Key bit 0 is the controller's next-state bit 0 wire itself.
- R6: The decoder accepts a key only when key[2:1] equals its expected colour. On an accepted key, the expected colour advances by 1 (mod 4) when key[0] differs from bit 0 of the expected colour, and holds otherwise. A rejected key sets err_o at that edge.
- R7: Suppose a stuck value on one D line changes that bit at an edge (bits 0 to 2 are the phase, bit 3 is the output). The corrupted phase or output appears after that edge with err_o still 0, and err_o rises at the following edge.
- R8: Suppose a stuck value on key line 2 or 1 differs from the correct bit. Then err_o rises at that same edge. A wrong stuck value on key line 0 raises err_o one edge later. Key forcing never changes phase_o or out_o.
- R9: Once err_o is 1 it stays 1 until reset, even after all forcing is removed.
- R10: A stuck value that equals the correct value of its line has no effect: phase_o, out_o and err_o behave as in the fault-free case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance request for the phase ring |
| ns_force_en | input | 4 | Per-line stuck enable on D lines (bits 2:0 phase, bit 3 output) |
| ns_force_val | input | 4 | Stuck value per D line |
| key_force_en | input | 3 | Per-line stuck enable on the key lines |
| key_force_val | input | 3 | Stuck value per key line |
| phase_o | output | 3 | Present phase (PH0 = 0 .. PH7 = 7) |
| out_o | output | 1 | Registered controller output |
| err_o | output | 1 | Sticky concurrent-error flag |

## Verification
A wrong phase or output bit in the state register changes that state's colour. The key built from it in the next cycle falls outside the row of the colour the decoder expects, so err_o rises exactly one edge after the corrupted value appears on phase_o or out_o. A wrong expected colour inside the decoder shows up the same way: err_o rises at the first edge where the correct key no longer matches it. The bench confirms both the one-edge latency and the silence of err_o in the edge where the fault lands.

// File: rtl/cced_pkg.sv
package cced_pkg;
    localparam int PH_W  = 3;
    localparam int EXT_W = PH_W + 1;   // phase bits plus output bit
    localparam int CLR_W = 2;
    localparam int KEY_W = CLR_W + 1;

    typedef enum logic [PH_W-1:0] {
        PH0 = 3'd0, PH1 = 3'd1, PH2 = 3'd2, PH3 = 3'd3,
        PH4 = 3'd4, PH5 = 3'd5, PH6 = 3'd6, PH7 = 3'd7
    } phase_e;

    // Colour of an extended state {out, phase}; a single flipped bit
    // always changes the colour.
    function automatic logic [CLR_W-1:0] colour_of(input logic [EXT_W-1:0] ext);
        return {ext[1], ext[0] ^ ext[2] ^ ext[3]};
    endfunction

    localparam logic [CLR_W-1:0] RST_CLR = colour_of(EXT_W'(0));
endpackage

// File: rtl/cced_stuck.sv
module cced_stuck #(
    parameter int W = 4
) (
    input  logic [W-1:0] line_i,
    input  logic [W-1:0] frc_en,
    input  logic [W-1:0] frc_val,
    output logic [W-1:0] line_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign line_o[b] = frc_en[b] ? frc_val[b] : line_i[b];
    end
endmodule

// File: rtl/cced_fsm.sv
module cced_fsm
    import cced_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic [EXT_W-1:0] frc_en,
    input  logic [EXT_W-1:0] frc_val,
    output phase_e           phase_q,
    output logic             out_q,
    output logic [EXT_W-1:0] nxt_ext
);
    phase_e           phase_n;
    logic             out_n;
    logic [EXT_W-1:0] d_ext;

    always_comb begin
        phase_n = phase_q;
        unique case (phase_q)
            PH0: if (adv_i) phase_n = PH1;
            PH1: if (adv_i) phase_n = PH2;
            PH2: if (adv_i) phase_n = PH3;
            PH3: if (adv_i) phase_n = PH4;
            PH4: if (adv_i) phase_n = PH5;
            PH5: if (adv_i) phase_n = PH6;
            PH6: if (adv_i) phase_n = PH7;
            PH7: if (adv_i) phase_n = PH0;
        endcase
    end

    always_comb out_n = phase_n inside {PH4, PH5, PH6, PH7};

    assign nxt_ext = {out_n, phase_n};

    // fault hooks sit on the D inputs, after the tap used by the key
    cced_stuck #(.W(EXT_W)) u_dstk (
        .line_i  (nxt_ext),
        .frc_en  (frc_en),
        .frc_val (frc_val),
        .line_o  (d_ext)
    );

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH0;
        else     phase_q <= phase_e'(d_ext[PH_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= d_ext[EXT_W-1];
    end
endmodule

// File: rtl/cced_keygen.sv
module cced_keygen
    import cced_pkg::*;
(
    input  logic [EXT_W-1:0] ps_ext,
    input  logic             ns_bit0,
    input  logic [KEY_W-1:0] frc_en,
    input  logic [KEY_W-1:0] frc_val,
    output logic [KEY_W-1:0] key_o
);
    logic [KEY_W-1:0] key_raw;

    // bit 0 shared with the next-state logic: next colour bit 0 equals
    // next phase bit 0 whenever output tracks phase bit 2
    assign key_raw = {colour_of(ps_ext), ns_bit0};

    cced_stuck #(.W(KEY_W)) u_kstk (
        .line_i  (key_raw),
        .frc_en  (frc_en),
        .frc_val (frc_val),
        .line_o  (key_o)
    );
endmodule

// File: rtl/cced_decoder.sv
module cced_decoder
    import cced_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] key_i,
    output logic [CLR_W-1:0] exp_q,
    output logic             err_q
);
    logic             key_ok;
    logic [CLR_W-1:0] exp_n;

    assign key_ok = (key_i[KEY_W-1:1] == exp_q);

    always_comb begin
        exp_n = exp_q;
        if (key_ok && (key_i[0] != exp_q[0]))
            exp_n = exp_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= RST_CLR;
            err_q <= 1'b0;
        end else begin
            exp_q <= exp_n;
            if (!key_ok) err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cced_top.sv
module cced_top
    import cced_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv_i,
    input  logic [3:0] ns_force_en,
    input  logic [3:0] ns_force_val,
    input  logic [2:0] key_force_en,
    input  logic [2:0] key_force_val,
    output logic [2:0] phase_o,
    output logic       out_o,
    output logic       err_o
);
    phase_e           phase_q;
    logic             out_q;
    logic [EXT_W-1:0] nxt_ext;
    logic [KEY_W-1:0] key_w;
    logic [CLR_W-1:0] exp_clr;

    cced_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv_i),
        .frc_en  (ns_force_en),
        .frc_val (ns_force_val),
        .phase_q (phase_q),
        .out_q   (out_q),
        .nxt_ext (nxt_ext)
    );

    cced_keygen u_key (
        .ps_ext  ({out_q, phase_q}),
        .ns_bit0 (nxt_ext[0]),
        .frc_en  (key_force_en),
        .frc_val (key_force_val),
        .key_o   (key_w)
    );

    cced_decoder u_dec (
        .clk   (clk),
        .rst   (rst),
        .key_i (key_w),
        .exp_q (exp_clr),
        .err_q (err_o)
    );

    assign phase_o = phase_q;
    assign out_o   = out_q;
endmodule

// File: rtl/cced_sva.sv
module cced_sva (
    input logic       clk,
    input logic       rst,
    input logic       adv_i,
    input logic [3:0] ns_force_en,
    input logic [2:0] key_force_en,
    input logic [2:0] phase_o,
    input logic       out_o,
    input logic       err_o,
    input logic [2:0] key_w,
    input logic [1:0] exp_clr
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (phase_o == 3'd0 && !out_o && !err_o && exp_clr == 2'd0));

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && ns_force_en == 4'd0) |=> phase_o == 3'($past(phase_o) + 3'd1));

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && ns_force_en == 4'd0) |=> $stable(phase_o));

    assert_out_tracks_R3: assert property (@(posedge clk) disable iff (rst)
        (ns_force_en == 4'd0) |=> out_o == phase_o[2]);

    assert_no_spurious_err_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> ($past(ns_force_en) != 4'd0 || $past(ns_force_en, 2) != 4'd0 ||
                          $past(key_force_en) != 3'd0 || $past(key_force_en, 2) != 3'd0));

    assert_bad_row_R6: assert property (@(posedge clk) disable iff (rst)
        (key_w[2:1] != exp_clr) |=> err_o);

    assert_sticky_err_R9: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind cced_top cced_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .adv_i        (adv_i),
    .ns_force_en  (ns_force_en),
    .key_force_en (key_force_en),
    .phase_o      (phase_o),
    .out_o        (out_o),
    .err_o        (err_o),
    .key_w        (key_w),
    .exp_clr      (exp_clr)
);

// File: tb/tb_cced_top.sv
module tb_cced_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv_i = 1'b0;
    logic [3:0] ns_force_en = '0, ns_force_val = '0;
    logic [2:0] key_force_en = '0, key_force_val = '0;
    logic [2:0] phase_o;
    logic       out_o, err_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [2:0] mp;   // model phase

    always #10 clk = ~clk;   // 50 MHz

    cced_top dut (
        .clk(clk), .rst(rst), .adv_i(adv_i),
        .ns_force_en(ns_force_en), .ns_force_val(ns_force_val),
        .key_force_en(key_force_en), .key_force_val(key_force_val),
        .phase_o(phase_o), .out_o(out_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; adv_i = 1'b0;
        ns_force_en = '0; key_force_en = '0;
        tick(); tick();
        rst = 1'b0; mp = 3'd0;
    endtask

    task automatic step(input logic a);
        adv_i = a;
        tick();
        if (a) mp = mp + 3'd1;
    endtask

    task automatic test_reset();
        rst = 1'b1; adv_i = 1'b1;
        tick(); tick();
        chk("R1 phase", 8'(phase_o), 8'd0);
        chk("R1 out", 8'(out_o), 8'd0);
        chk("R1 err", 8'(err_o), 8'd0);
        rst = 1'b0; adv_i = 1'b0; mp = 3'd0;
    endtask

    task automatic test_walk();
        logic [11:0] pat = 12'b1101_1111_0111;
        do_reset();
        for (int i = 0; i < 12; i++) begin
            step(pat[i]);
            chk("R2 phase", 8'(phase_o), 8'(mp));
            chk("R3 out", 8'(out_o), 8'(mp[2]));
        end
        chk("R4 err after walk", 8'(err_o), 8'd0);
    endtask

    task automatic test_long_run();
        logic [7:0] lf = 8'hA5;
        int bad = 0;
        do_reset();
        for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(lf[0]);
            if (phase_o !== mp || out_o !== mp[2]) bad++;
        end
        chk("R2 R3 long-run mismatches", 8'(bad), 8'd0);
        chk("R4 err after long run", 8'(err_o), 8'd0);
    endtask

    // stuck-at on one D line, value chosen to flip the bit at the faulted edge
    task automatic test_ns_fault(input int k);
        logic [3:0] good, bad;
        do_reset();
        for (int i = 0; i < k + 2; i++) step(1'b1);
        good = {3'(mp + 3'd1) >= 3'd4, 3'(mp + 3'd1)};
        bad  = good ^ (4'd1 << k);
        ns_force_en = 4'd1 << k;
        ns_force_val = bad;
        adv_i = 1'b1;
        tick();
        ns_force_en = '0; adv_i = 1'b0;
        chk("R7 corrupted phase", 8'(phase_o), 8'(bad[2:0]));
        chk("R7 corrupted out", 8'(out_o), 8'(bad[3]));
        chk("R7 err quiet at faulted edge", 8'(err_o), 8'd0);
        tick();
        chk("R7 err one edge later", 8'(err_o), 8'd1);
        for (int i = 0; i < 3; i++) tick();
        chk("R9 err sticky", 8'(err_o), 8'd1);
        do_reset();
        chk("R9 err cleared by reset", 8'(err_o), 8'd0);
    endtask

    task automatic test_key_fault();
        // key line 2 at PH0: correct 0, stuck 1
        do_reset();
        key_force_en = 3'b100; key_force_val = 3'b100;
        tick();
        key_force_en = '0;
        chk("R8 key2 flagged same edge", 8'(err_o), 8'd1);
        chk("R8 phase unaffected", 8'(phase_o), 8'd0);
        // key line 1 at PH0: correct 0, stuck 1
        do_reset();
        key_force_en = 3'b010; key_force_val = 3'b010;
        tick();
        key_force_en = '0;
        chk("R8 key1 flagged same edge", 8'(err_o), 8'd1);
        // key line 0 at PH0 advancing: correct 1, stuck 0
        do_reset();
        key_force_en = 3'b001; key_force_val = 3'b000; adv_i = 1'b1;
        tick();
        key_force_en = '0; adv_i = 1'b0;
        chk("R8 key0 quiet first edge", 8'(err_o), 8'd0);
        chk("R8 phase advanced normally", 8'(phase_o), 8'd1);
        tick();
        chk("R6 R8 key0 flagged one edge later", 8'(err_o), 8'd1);
    endtask

    task automatic test_benign();
        do_reset();
        ns_force_en = 4'b0001; ns_force_val = 4'b0001; adv_i = 1'b1;
        tick();
        ns_force_en = '0; adv_i = 1'b0;
        chk("R10 phase with matching stuck", 8'(phase_o), 8'd1);
        key_force_en = 3'b100; key_force_val = 3'b000;
        tick(); tick();
        key_force_en = '0;
        chk("R10 err with matching stuck", 8'(err_o), 8'd0);
        // R5 R6: decoder followed colours 0 -> 1 across PH0 -> PH1; step on
        step(1'b1); step(1'b1); step(1'b1);
        chk("R5 R6 colour tracking", 8'(err_o), 8'd0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_walk();
        test_long_run();
        for (int k = 0; k < 4; k++) test_ns_fault(k);
        test_key_fault();
        test_benign();
        summary();
    end
endmodule